// File: doc/BRIEF.md
# Synchronous Peripheral Address Sequencer

This block is the host side of a three-wire scheme for selecting serial peripherals. The three wires are an enable line, a clock/handshake line and a data line. It also watches a shared service-request line. When a request with a 4-bit device number arrives while the block is idle, it first drives enable, clock and data low together. This puts every attached device into its reset state, and the block holds that state for a configurable minimum number of cycles.

It then opens the addressing phase. The clock line goes high first, the enable line follows half a bit later, and the data line stays low through both transitions. The block then shifts out an 8-bit address byte, least significant bit first. The byte is `{3'b000, dev[3:0], 1'b1}`, so the first bit on the wire is always 1. Data changes only while the clock is low, and each bit is stable across the clock's rising edge.

The bit rate comes from a half-period divider input, which is latched when a request is accepted. After the eighth rising edge the block issues a one-cycle completion pulse and leaves enable and clock high. While enable and clock are both low, a high service-request line is reported on a registered flag.

Top module: `sync_addr_seq`

## Requirements
- R1: A request (`start_i` high at a clock edge while `busy_o` is low) raises `busy_o` at that edge. From that edge, `sel_en_o`, `shk_clk_o` and `ser_dat_o` are all low for exactly RST_MIN_CYC cycles.
- R2: `shk_clk_o` rises at the end of the reset hold. `sel_en_o` rises H cycles later. `sel_en_o` never rises while `shk_clk_o` is low, or in the cycle right after a clock rise.
- R3: `ser_dat_o` is 0 whenever `sel_en_o` is low, including the cycles in which clock and enable are raised.
- R4: Exactly eight address bits are sent, least significant first, one per clock rising edge that occurs with enable high. The byte equals `{3'b000, dev_i[3:0], 1'b1}`, so bit 0 is always 1.
- R5: `ser_dat_o` changes only on the falling clock transition and is stable while the clock is high. Each clock level lasts H cycles, so consecutive address rising edges are 2H cycles apart. H is `half_div_i` latched at request acceptance, with 0 treated as 1. A later change of `half_div_i` has no effect on the run in progress.
- R6: A request made while `busy_o` is high is ignored. The address and timing of the run in progress are unchanged.
- R7: `done_o` pulses high for one cycle, H cycles after the eighth address rising edge, and becomes visible RST_MIN_CYC+18H cycles after the accepting edge. In that same cycle `busy_o` goes low. `sel_en_o` and `shk_clk_o` then stay high until the next request.
- R8: `svc_pend_o` is high in the cycle after an edge at which `svc_line_i` was high while `sel_en_o` and `shk_clk_o` were both low, and is low otherwise.
- R9: After synchronous reset, `busy_o`, `done_o`, `sel_en_o`, `shk_clk_o`, `ser_dat_o` and `svc_pend_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to address a device |
| dev_i | input | DEV_W | Device number for the request |
| half_div_i | input | DIV_W | Cycles per half bit period (0 means 1) |
| svc_line_i | input | 1 | Shared service-request line from devices |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sel_en_o | output | 1 | Device enable line |
| shk_clk_o | output | 1 | Clock/handshake line |
| ser_dat_o | output | 1 | Serial address data line |
| svc_pend_o | output | 1 | Registered service-request indication |

## Verification
Counting from the edge that accepts a request as cycle 0, the outputs follow a fixed schedule:
- The reset levels appear one cycle later.
- The clock rises after RST_MIN_CYC cycles, and enable follows H cycles after that.
- Address bit i is captured on the rise RST_MIN_CYC+3H+2Hi cycles after acceptance.
- `done_o` appears after RST_MIN_CYC+18H cycles.
- `svc_pend_o` lags the line it reports by one edge.

The bench drives inputs and samples every output on the falling clock edge. It numbers each sample from the accepting edge and compares the sample index of every observed transition against these formulas computed from the latched H. It rebuilds the address byte from the data line at each rising clock edge.

// File: rtl/sync_addr_seq_pkg.sv
package sync_addr_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RST   = 3'd1,
    PH_CLKUP = 3'd2,
    PH_ENUP  = 3'd3,
    PH_LOW   = 3'd4,
    PH_HIGH  = 3'd5
  } phase_t;

endpackage

// File: rtl/sync_addr_seq_timer.sv
module sync_addr_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;

  // limit_i is at least 1 in every phase that uses it
  assign expire_o = (cnt_q == limit_i - CW'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i || expire_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/sync_addr_seq_shift.sv
module sync_addr_seq_shift #(
  parameter int ADDR_W = 8,
  parameter int DEV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic             shift_i,
  output logic             bit_o,
  output logic             last_o
);

  localparam int PAD = ADDR_W - DEV_W - 1;
  localparam int NW  = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] sh_q;
  logic [NW-1:0]     sent_q;

  assign bit_o  = sh_q[0];
  assign last_o = (sent_q == NW'(ADDR_W));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q   <= '0;
      sent_q <= '0;
    end else if (load_i) begin
      sh_q   <= {{PAD{1'b0}}, dev_i, 1'b1};
      sent_q <= '0;
    end else if (shift_i) begin
      sh_q   <= {1'b0, sh_q[ADDR_W-1:1]};
      sent_q <= sent_q + NW'(1);
    end
  end

endmodule

// File: rtl/sync_addr_seq_ctrl.sv
module sync_addr_seq_ctrl
  import sync_addr_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int CW          = 8,
  parameter int RST_MIN_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             tmr_exp_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic             tmr_clear_o,
  output logic [CW-1:0]    tmr_limit_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             en_o,
  output logic             clk_o,
  output logic             dat_o
);

  phase_t           phase_q;
  logic [DIV_W-1:0] hlim_q;
  logic             en_q, clk_q, dat_q, done_q;

  always_comb begin
    tmr_clear_o = (phase_q == PH_IDLE);
    tmr_limit_o = (phase_q == PH_RST) ? CW'(RST_MIN_CYC) : CW'(hlim_q);
    load_o      = (phase_q == PH_IDLE) && start_i;
    shift_o     = tmr_exp_i &&
                  ((phase_q == PH_ENUP) || ((phase_q == PH_HIGH) && !last_i));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= PH_IDLE;
      hlim_q  <= DIV_W'(1);
      en_q    <= 1'b0;
      clk_q   <= 1'b0;
      dat_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_RST;
          en_q    <= 1'b0;
          clk_q   <= 1'b0;
          dat_q   <= 1'b0;
          hlim_q  <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
        end
        PH_RST: if (tmr_exp_i) begin
          phase_q <= PH_CLKUP;
          clk_q   <= 1'b1;
        end
        PH_CLKUP: if (tmr_exp_i) begin
          phase_q <= PH_ENUP;
          en_q    <= 1'b1;
        end
        PH_ENUP: if (tmr_exp_i) begin
          phase_q <= PH_LOW;
          clk_q   <= 1'b0;
          dat_q   <= bit_i;
        end
        PH_LOW: if (tmr_exp_i) begin
          phase_q <= PH_HIGH;
          clk_q   <= 1'b1;
        end
        PH_HIGH: if (tmr_exp_i) begin
          if (last_i) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            phase_q <= PH_LOW;
            clk_q   <= 1'b0;
            dat_q   <= bit_i;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;
  assign en_o   = en_q;
  assign clk_o  = clk_q;
  assign dat_o  = dat_q;

endmodule

// File: rtl/sync_addr_seq.sv
module sync_addr_seq #(
  parameter int DEV_W       = 4,
  parameter int ADDR_W      = 8,
  parameter int DIV_W       = 8,
  parameter int RST_MIN_CYC = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             svc_line_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sel_en_o,
  output logic             shk_clk_o,
  output logic             ser_dat_o,
  output logic             svc_pend_o
);

  localparam int RW = $clog2(RST_MIN_CYC + 1);
  localparam int CW = (RW > DIV_W) ? RW : DIV_W;

  logic          tmr_clear, tmr_exp, load, shift, bit_nx, last;
  logic [CW-1:0] tmr_limit;
  logic          svc_q;

  sync_addr_seq_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clear_i  (tmr_clear),
    .limit_i  (tmr_limit),
    .expire_o (tmr_exp)
  );

  sync_addr_seq_shift #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_shift (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .load_i  (load),
    .dev_i   (dev_i),
    .shift_i (shift),
    .bit_o   (bit_nx),
    .last_o  (last)
  );

  sync_addr_seq_ctrl #(
    .DIV_W(DIV_W), .CW(CW), .RST_MIN_CYC(RST_MIN_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .half_div_i  (half_div_i),
    .tmr_exp_i   (tmr_exp),
    .bit_i       (bit_nx),
    .last_i      (last),
    .tmr_clear_o (tmr_clear),
    .tmr_limit_o (tmr_limit),
    .load_o      (load),
    .shift_o     (shift),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .en_o        (sel_en_o),
    .clk_o       (shk_clk_o),
    .dat_o       (ser_dat_o)
  );

  // service request is meaningful only while both lines hold devices in reset
  always_ff @(posedge clk_i) begin
    if (rst_i) svc_q <= 1'b0;
    else       svc_q <= svc_line_i && !sel_en_o && !shk_clk_o;
  end

  assign svc_pend_o = svc_q;

endmodule

// File: rtl/sync_addr_seq_chk.sv
module sync_addr_seq_chk (
  input logic clk_i,
  input logic rst_i,
  input logic busy_o,
  input logic done_o,
  input logic sel_en_o,
  input logic shk_clk_o,
  input logic ser_dat_o,
  input logic svc_pend_o
);

  AST_RESET_LINES_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> (!sel_en_o && !shk_clk_o && !ser_dat_o)); // R1

  AST_EN_AFTER_CLK: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sel_en_o) |-> (shk_clk_o && $past(shk_clk_o))); // R2

  AST_DATA_LOW_NO_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    !sel_en_o |-> !ser_dat_o); // R3

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    (shk_clk_o && $past(shk_clk_o)) |-> $stable(ser_dat_o)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o); // R7

  AST_DONE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (sel_en_o && shk_clk_o && !busy_o)); // R7

  AST_SVC_IN_RESET: assert property (@(posedge clk_i) disable iff (rst_i)
    svc_pend_o |-> $past(!sel_en_o && !shk_clk_o)); // R8

  AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (!busy_o && !done_o && !sel_en_o && !shk_clk_o && !svc_pend_o)); // R9

endmodule

bind sync_addr_seq sync_addr_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sel_en_o   (sel_en_o),
  .shk_clk_o  (shk_clk_o),
  .ser_dat_o  (ser_dat_o),
  .svc_pend_o (svc_pend_o)
);

// File: tb/tb_sync_addr_seq.sv
module tb_sync_addr_seq;

  localparam int DEV_W = 4;
  localparam int DIV_W = 8;
  localparam int RST   = 6;

  // vector: {dev[3:0], half_div[7:0], ring}
  localparam logic [12:0] VEC [0:4] = '{
    {4'd5,  8'd2, 1'b1},
    {4'd0,  8'd1, 1'b0},
    {4'd15, 8'd3, 1'b1},
    {4'd10, 8'd0, 1'b0},
    {4'd9,  8'd4, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst_i, start_i, svc_line_i;
  logic [DEV_W-1:0] dev_i;
  logic [DIV_W-1:0] half_div_i;
  logic busy_o, done_o, sel_en_o, shk_clk_o, ser_dat_o, svc_pend_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sync_addr_seq #(.DEV_W(DEV_W), .DIV_W(DIV_W), .RST_MIN_CYC(RST)) dut (
    .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .dev_i(dev_i),
    .half_div_i(half_div_i), .svc_line_i(svc_line_i), .busy_o(busy_o),
    .done_o(done_o), .sel_en_o(sel_en_o), .shk_clk_o(shk_clk_o),
    .ser_dat_o(ser_dat_o), .svc_pend_o(svc_pend_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic [3:0] dv, input logic [7:0] hd,
                         input bit rg, input bit poke);
    int h, lowcnt, en_k, clk_k, done_k, ndone, nb, last_k, rise_err;
    int dat_err, stab_err, svc_rst, svc_done;
    logic [7:0] got, exp_b;
    logic pc, pe, pd;
    h = (hd == 0) ? 1 : int'(hd);
    exp_b = {3'b000, dv, 1'b1};
    lowcnt = 0; en_k = 0; clk_k = 0; done_k = 0; ndone = 0; nb = 0; last_k = 0;
    rise_err = 0; dat_err = 0; stab_err = 0; svc_rst = -1; svc_done = -1; got = '0;
    @(negedge clk);
    dev_i = dv; half_div_i = hd; svc_line_i = rg; start_i = 1'b1;
    pc = shk_clk_o; pe = sel_en_o; pd = ser_dat_o;
    for (int k = 1; k <= RST + 18*h + 3; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (poke && k == 3) begin start_i = 1'b1; dev_i = ~dv; half_div_i = 8'd7; end
      if (poke && k == 4) start_i = 1'b0;
      if (k <= RST && !sel_en_o && !shk_clk_o && !ser_dat_o) lowcnt++;
      if (k == RST) svc_rst = svc_pend_o;
      if (shk_clk_o && !pc && clk_k == 0) clk_k = k;
      if (sel_en_o && !pe) begin
        en_k = k;
        if (!(shk_clk_o && pc)) rise_err++;
      end
      if (!sel_en_o && ser_dat_o) dat_err++;
      if (shk_clk_o && pc && ser_dat_o != pd) stab_err++;
      if (shk_clk_o && !pc && sel_en_o && pe) begin
        if (nb < 8) got[nb] = ser_dat_o;
        if (nb == 0) begin
          if (k != RST + 3*h + 1) rise_err++;
        end else if (k - last_k != 2*h) rise_err++;
        nb++; last_k = k;
      end
      if (done_o) begin
        ndone++;
        if (done_k == 0) begin done_k = k; svc_done = svc_pend_o; end
      end
      pc = shk_clk_o; pe = sel_en_o; pd = ser_dat_o;
    end
    chk(lowcnt == RST,            "R1 reset hold", lowcnt, RST);
    chk(clk_k == RST + 1,         "R2 clock rise", clk_k, RST + 1);
    chk(en_k == RST + h + 1,      "R2 enable rise", en_k, RST + h + 1);
    chk(dat_err == 0,             "R3 data low", dat_err, 0);
    chk(nb == 8,                  "R4 bit count", nb, 8);
    chk(got == exp_b,             poke ? "R6 ignored request" : "R4 address byte",
        int'(got), int'(exp_b));
    chk(rise_err == 0,            "R5 rise spacing", rise_err, 0);
    chk(stab_err == 0,            "R5 data stable", stab_err, 0);
    chk(done_k == RST + 18*h + 1, "R7 done time", done_k, RST + 18*h + 1);
    chk(ndone == 1,               "R7 done single", ndone, 1);
    chk(sel_en_o && shk_clk_o && !busy_o, "R7 lines high", {sel_en_o, shk_clk_o, busy_o}, 3'b110);
    chk(svc_rst == int'(rg),      "R8 ring in reset", svc_rst, int'(rg));
    chk(svc_done == 0,            "R8 ring in addressing", svc_done, 0);
    svc_line_i = 1'b0;
  endtask

  initial begin
    rst_i = 1'b1; start_i = 1'b0; dev_i = '0; half_div_i = 8'd1; svc_line_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    chk({busy_o, done_o, sel_en_o, shk_clk_o, ser_dat_o, svc_pend_o} == 6'b0,
        "R9 reset state", {busy_o, done_o, sel_en_o, shk_clk_o, ser_dat_o, svc_pend_o}, 0);

    // R8: idle with lines low reports the ring line one edge later
    svc_line_i = 1'b1;
    @(negedge clk);
    chk(svc_pend_o == 1'b1, "R8 idle ring high", svc_pend_o, 1);
    svc_line_i = 1'b0;
    @(negedge clk);
    chk(svc_pend_o == 1'b0, "R8 idle ring low", svc_pend_o, 0);

    foreach (VEC[i]) run_seq(VEC[i][12:9], VEC[i][8:1], VEC[i][0], 1'b0);

    // R6 and R5 latch: mid-run request and divider change are ignored
    run_seq(4'd3, 8'd2, 1'b1, 1'b1);

    // R7: lines stay high while idle; R8: ring with lines high is not reported
    svc_line_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(sel_en_o && shk_clk_o, "R7 idle lines high", {sel_en_o, shk_clk_o}, 3);
    chk(svc_pend_o == 1'b0, "R8 ring with lines high", svc_pend_o, 0);
    svc_line_i = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule